// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog counter clocked by the system clock. Software restarts it now and then with a one-cycle restart strobe. If the restarts stop, the counter reaches the selected timeout. At that point it sets an interrupt flag and opens a fixed grace window. If no restart arrives before the window closes, the block issues a one-cycle system reset pulse. Software thus gets one warning, through the interrupt, before the hard reset.

A 2-bit interval code chooses one of four power-of-two timeouts. The code is latched only at reset and at each restart. The interrupt output and the reset pulse each have their own enable. A sticky status bit records that a watchdog reset was issued, and only the block's own reset clears it. The CPU, the interrupt controller and reset distribution are outside this block.

Top module: `wdt_two_stage`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `timeout_flag`, `irq`, `wd_reset` and `wd_reset_seen` are all 0.
- R2: Let N be the timeout of the latched interval code k (0 to 3), where N = 2^(BASE_EXP+k) cycles. `timeout_flag` becomes 1 exactly N clock edges after the restart edge, or after the first edge at which reset is released. With the default BASE_EXP of 15, the codes select 2^15, 2^16, 2^17 and 2^18 cycles.
- R3: `timeout_flag` is set whether or not interrupts are enabled. `irq` is 1 only while both `timeout_flag` and `irq_en` are 1, and it follows `irq_en` without a clock delay.
- R4: Once set, `timeout_flag` stays 1, through restarts as well, until an edge at which `flag_clr` is 1. A restart does not clear it.
- R5: If no restart is sampled during the grace window, `wd_reset` is 1 for exactly one cycle, starting GRACE_CYCLES edges after the edge that set the timeout.
- R6: If `rst_en` is 0 on the edge that closes the window, no pulse is issued and `wd_reset_seen` keeps its value.
- R7: A restart clears the counter and cancels any open grace window. This holds when the restart lands on the last edge of the window, and also when it lands on the edge that would have reached the timeout. In both cases no reset pulse and no new timeout follow, and a full interval starts again from that edge.
- R8: A change of `interval_sel` has no effect until the next restart. The interval already running keeps its length.
- R9: `wd_reset_seen` becomes 1 together with any issued reset pulse and stays 1 until `rst`.
- R10: When a window closes without a restart, counting starts again from zero. The next timeout comes N edges after the closing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_sel | input | 2 | Interval code, latched at reset and at restart |
| irq_en | input | 1 | Interrupt output enable |
| rst_en | input | 1 | Reset pulse enable |
| kick | input | 1 | Restart strobe, one cycle |
| flag_clr | input | 1 | Clears the timeout flag |
| timeout_flag | output | 1 | Timeout interrupt flag |
| irq | output | 1 | Flag gated by `irq_en` |
| wd_reset | output | 1 | One-cycle system reset pulse |
| wd_reset_seen | output | 1 | Sticky record of an issued reset pulse |

## Verification
The bench measures the edge distance from restart to flag for all four codes, and from flag to pulse. An off-by-one in either comparison would therefore move the measured count by one.

Restarts are placed on the last grace edge and on the exact timeout edge. A design that let the expiry or the timeout win over the restart would then emit a pulse or a flag. An interval code that is changed without a restart must keep the old length, so a design that tracked the input live would time out early or late. With the reset enable off, a design that ignored it would pulse or set the sticky bit. After an expiry, a design that did not restart from zero would produce a wrong second timeout distance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Where the watchdog sits: counting toward timeout, or inside the grace window
    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_GRACE = 1'b1
    } wdt_phase_e;

    // Events passed from the counters to the status logic
    typedef struct packed {
        logic timeout;   // interval reached on this edge
        logic expire;    // grace window closed on this edge without restart
    } wdt_evt_t;

    // Number of system clocks selected by an interval code
    function automatic int unsigned interval_cycles(input int unsigned exp_base,
                                                    input logic [1:0] code);
        return 32'd1 << (exp_base + 32'(code));
    endfunction

endpackage

// File: rtl/wdt_interval_ctr.sv
module wdt_interval_ctr #(
    parameter int unsigned BASE_EXP = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick,
    input  logic       hold,
    input  logic [1:0] sel_in,
    output logic       tick
);
    localparam int unsigned CW = BASE_EXP + 3;

    logic [CW-1:0] cnt;
    logic [1:0]    sel_q;
    logic [CW-1:0] limit_m1;

    assign limit_m1 = CW'(wdt_pkg::interval_cycles(BASE_EXP, sel_q) - 32'd1);
    assign tick     = !kick && !hold && (cnt == limit_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= sel_in;
        end else if (kick) begin
            cnt   <= '0;
            sel_q <= sel_in;
        end else if (hold || tick) begin
            cnt   <= '0;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // The counter rests at zero for the whole grace window (R10)
    assert_idle_in_grace_R10: assert property (@(posedge clk) disable iff (rst)
        hold |-> cnt == '0);

    // Latched code only moves on a restart (R8)
    assert_sel_latched_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(kick) |-> $stable(sel_q));

endmodule

// File: rtl/wdt_grace_win.sv
module wdt_grace_win #(
    parameter int unsigned GRACE_CYCLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic active,
    output logic expire
);
    localparam int unsigned GW = (GRACE_CYCLES > 2) ? $clog2(GRACE_CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(GRACE_CYCLES - 1);

    wdt_pkg::wdt_phase_e phase;
    logic [GW-1:0]       gcnt;

    assign active = (phase == wdt_pkg::PH_GRACE);
    assign expire = active && !cancel && (gcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || cancel || expire) begin
            phase <= wdt_pkg::PH_COUNT;
            gcnt  <= '0;
        end else if (start) begin
            phase <= wdt_pkg::PH_GRACE;
            gcnt  <= '0;
        end else if (active) begin
            gcnt  <= gcnt + 1'b1;
        end
    end

    // A new timeout can only come while no window is open (R5)
    assert_start_outside_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

    // A restart closes the window on the next cycle (R7)
    assert_cancel_closes_R7: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !active);

endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic              clk,
    input  logic              rst,
    input  wdt_pkg::wdt_evt_t evt,
    input  logic              flag_clr,
    input  logic              irq_en,
    input  logic              rst_en,
    output logic              flag,
    output logic              irq,
    output logic              wd_reset,
    output logic              seen
);
    logic fire;

    assign fire = evt.expire && rst_en;
    assign irq  = flag && irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag     <= 1'b0;
            wd_reset <= 1'b0;
            seen     <= 1'b0;
        end else begin
            if (evt.timeout)   flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
            wd_reset <= fire;
            if (fire) seen <= 1'b1;
        end
    end

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wd_reset |=> !wd_reset);

    assert_pulse_enabled_R6: assert property (@(posedge clk) disable iff (rst)
        wd_reset |-> $past(rst_en));

    assert_flag_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        seen |=> seen);

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
    parameter int unsigned BASE_EXP     = 15,
    parameter int unsigned GRACE_CYCLES = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] interval_sel,
    input  logic       irq_en,
    input  logic       rst_en,
    input  logic       kick,
    input  logic       flag_clr,
    output logic       timeout_flag,
    output logic       irq,
    output logic       wd_reset,
    output logic       wd_reset_seen
);
    wdt_pkg::wdt_evt_t evt;
    logic              in_grace;

    wdt_interval_ctr #(.BASE_EXP(BASE_EXP)) u_interval (
        .clk    (clk),
        .rst    (rst),
        .kick   (kick),
        .hold   (in_grace),
        .sel_in (interval_sel),
        .tick   (evt.timeout)
    );

    wdt_grace_win #(.GRACE_CYCLES(GRACE_CYCLES)) u_grace (
        .clk    (clk),
        .rst    (rst),
        .start  (evt.timeout),
        .cancel (kick),
        .active (in_grace),
        .expire (evt.expire)
    );

    wdt_status u_status (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .rst_en   (rst_en),
        .flag     (timeout_flag),
        .irq      (irq),
        .wd_reset (wd_reset),
        .seen     (wd_reset_seen)
    );

    // No reset pulse on the cycle after a restart was sampled (R7)
    assert_kick_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        kick |=> !wd_reset);

endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
    localparam int unsigned BE = 6;
    localparam int unsigned G  = 32;

    typedef struct packed {
        logic [1:0]  sel;
        logic        ien;
        logic        ren;
        logic [15:0] exp_to;
        logic [15:0] exp_gap;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 1'b1, 1'b1, 16'd64,  16'd32},
        '{2'd1, 1'b0, 1'b1, 16'd128, 16'd32},
        '{2'd2, 1'b1, 1'b0, 16'd256, 16'd0},
        '{2'd3, 1'b1, 1'b1, 16'd512, 16'd32}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] interval_sel = 2'd0;
    logic irq_en = 1'b0, rst_en = 1'b0, kick = 1'b0, flag_clr = 1'b0;
    logic timeout_flag, irq, wd_reset, wd_reset_seen;

    int errs = 0, checks = 0, pulses = 0;

    always #2 clk = ~clk;

    wdt_two_stage #(.BASE_EXP(BE), .GRACE_CYCLES(G)) uut (
        .clk(clk), .rst(rst), .interval_sel(interval_sel), .irq_en(irq_en),
        .rst_en(rst_en), .kick(kick), .flag_clr(flag_clr),
        .timeout_flag(timeout_flag), .irq(irq), .wd_reset(wd_reset),
        .wd_reset_seen(wd_reset_seen)
    );

    always @(negedge clk) if (!rst && wd_reset) pulses++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Edges until the flag is seen (0 = not within limit)
    task automatic wait_flag(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (timeout_flag) begin n = i; break; end
        end
    endtask

    task automatic wait_rst(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); @(negedge clk);
            if (wd_reset) begin n = i; break; end
        end
    endtask

    task automatic restart(input logic [1:0] sel, input logic clr);
        interval_sel = sel; kick = 1'b1; flag_clr = clr;
        @(negedge clk);
        kick = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        int n, p;
        repeat (3) @(negedge clk);
        chk(!timeout_flag && !irq && !wd_reset && !wd_reset_seen, "R1 outputs in reset",
            {timeout_flag, irq, wd_reset, wd_reset_seen}, 0);
        rst = 1'b0;

        // R2: code latched at reset, first timeout
        wait_flag(600, n);
        chk(n == 64, "R2 first timeout after reset", n, 64);
        chk(irq == 1'b0, "R3 irq masked while flag set", irq, 0);
        irq_en = 1'b1; #1;
        chk(irq == 1'b1, "R3 irq follows enable", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        // R6: window closes with reset disabled
        wait_rst(G + 8, n);
        chk(n == 0, "R6 no pulse when disabled", n, 0);
        chk(wd_reset_seen == 1'b0, "R6 sticky untouched", wd_reset_seen, 0);

        // Vector table
        foreach (VECS[vi]) begin
            irq_en = VECS[vi].ien; rst_en = VECS[vi].ren;
            restart(VECS[vi].sel, 1'b1);
            chk(timeout_flag == 1'b0, "R4 flag cleared", timeout_flag, 0);
            wait_flag(1200, n);
            chk(n == int'(VECS[vi].exp_to), "R2 interval timeout", n, int'(VECS[vi].exp_to));
            chk(irq == VECS[vi].ien, "R3 irq gating", irq, VECS[vi].ien);
            wait_rst(G + 8, n);
            if (VECS[vi].ren) begin
                chk(n == int'(VECS[vi].exp_gap), "R5 grace length", n, int'(VECS[vi].exp_gap));
                @(negedge clk);
                chk(wd_reset == 1'b0, "R5 pulse one cycle", wd_reset, 0);
                chk(wd_reset_seen == 1'b1, "R9 sticky set", wd_reset_seen, 1);
            end else begin
                chk(n == 0, "R6 pulse gated off", n, 0);
            end
        end

        // R10: restart from zero after expiry
        rst_en = 1'b1;
        restart(2'd0, 1'b1);
        wait_flag(200, n);
        wait_rst(G + 8, n);
        chk(n == G, "R5 grace length code 0", n, G);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(timeout_flag == 1'b0 && wd_reset == 1'b0, "R10 cleared after pulse",
            {timeout_flag, wd_reset}, 0);
        wait_flag(200, n);
        chk(n == 63, "R10 next timeout after expiry", n, 63);

        // R4: flag survives a restart, then clears
        restart(2'd0, 1'b0);
        repeat (5) @(negedge clk);
        chk(timeout_flag == 1'b1, "R4 flag persists over restart", timeout_flag, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(timeout_flag == 1'b0, "R4 flag_clr clears", timeout_flag, 0);

        // R7: restart on the last grace edge
        restart(2'd0, 1'b1);
        wait_flag(200, n);
        repeat (G - 1) @(negedge clk);
        p = pulses;
        restart(2'd0, 1'b0);
        repeat (8) @(negedge clk);
        chk(pulses == p, "R7 last-edge restart blocks pulse", pulses - p, 0);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        wait_flag(200, n);
        chk(n == 55, "R7 full interval after restart", n, 55);

        // R7: restart on the timeout edge
        restart(2'd0, 1'b1);
        repeat (63) @(negedge clk);
        restart(2'd0, 1'b0);
        chk(timeout_flag == 1'b0, "R7 restart beats timeout", timeout_flag, 0);
        wait_flag(200, n);
        chk(n == 64, "R7 interval from restart", n, 64);

        // R8: code change without restart
        restart(2'd0, 1'b1);
        interval_sel = 2'd2;
        wait_flag(600, n);
        chk(n == 64, "R8 old interval kept", n, 64);
        restart(2'd2, 1'b1);
        wait_flag(600, n);
        chk(n == 256, "R8 new interval after restart", n, 256);

        // R9: sticky cleared only by reset
        chk(wd_reset_seen == 1'b1, "R9 sticky still set", wd_reset_seen, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(wd_reset_seen == 1'b0 && timeout_flag == 1'b0, "R9 R1 cleared by reset",
            {wd_reset_seen, timeout_flag}, 0);
        report();
    end
endmodule